// File: doc/BRIEF.md
# Page Program and Erase Sequencer

This block runs the self-timed write operations of a small serial flash array. The command decoder gives it three things: the opcode class together with the 16-bit target address, each data byte as it completes on the serial line, and a one-cycle pulse when chip select rises. The pulse carries a flag that says whether the bit counter was at a byte boundary at that moment. Program data is collected into a page buffer. The buffer is addressed by a column pointer that starts at the low address bits and wraps inside the page.

The operation is committed only when four conditions hold on the chip-select rise: the rise is byte aligned, write enable is set, the protection logic reports the target as not locked out, and, for a program, at least one byte was supplied. After the commit the block raises busy for a parameterised number of clocks. During that window it replays the buffered bytes to the array write port, one per clock, or issues a single erase pulse for one half of the array or for the whole array. In the last busy clock it pulses a request that clears the write-enable latch. Cycle times are given in clock cycles, not in physical time.

Top module: `pgm_erase_seq`

## Requirements
- R1: After reset, `busy`, `arr_we`, `arr_erase` and `wen_clr` are all low.
- R2: A program command (`cmd_kind` = 2'b01) with n supplied bytes, 1 ≤ n ≤ 128, writes those bytes through `arr_we`, one per clock. The writes start in the first busy clock, go in column order from the start column (`cmd_addr[6:0]`), and use address = {`cmd_addr[15:7]`, column}.
- R3: The column pointer wraps from 127 to 0 within the same page. When more than 128 bytes are supplied, each later byte replaces the earlier byte at the same column, and exactly 128 writes are issued. Columns that received no byte are not written.
- R4: A commit happens only on a `cs_rise` pulse with `byte_aligned` high. A `cs_rise` without alignment discards the pending command, and `busy` stays low.
- R5: A program or erase command whose `cs_rise` arrives while `wen` is low is ignored, and `busy` stays low.
- R6: If `lock_hit` is high on the committing `cs_rise`, the command is dropped without raising `busy` and without pulsing `wen_clr`.
- R7: A sector erase (`cmd_kind` = 2'b10) raises `arr_erase` for exactly the first busy clock, with `arr_erase_chip` low. `arr_addr` is the sector base: address bit 15 is kept and all lower bits are zero.
- R8: A chip erase (`cmd_kind` = 2'b11) raises `arr_erase` together with `arr_erase_chip` for the first busy clock, with `arr_addr` = 0.
- R9: `busy` rises in the clock after the commit. It stays high for n×BYTE_CYC clocks for a program, SECT_CYC clocks for a sector erase, and CHIP_CYC clocks for a chip erase.
- R10: `wen_clr` is high for exactly one clock per completed operation, and that clock is the last busy clock.
- R11: While `busy` is high, `cmd_start`, `data_stb` and `cs_rise` have no effect. No second operation follows.
- R12: A program command that ends with no data byte supplied is discarded, and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Pulse: opcode and address decoded |
| cmd_kind | input | 2 | 01 program, 10 sector erase, 11 chip erase |
| cmd_addr | input | 16 | Target address of the command |
| data_stb | input | 1 | Pulse: one program data byte complete |
| data_byte | input | 8 | Program data byte |
| cs_rise | input | 1 | Pulse: chip select went high |
| byte_aligned | input | 1 | Bit counter was at a byte boundary at `cs_rise` |
| wen | input | 1 | Write-enable latch state |
| lock_hit | input | 1 | Protection logic: pending target is locked out |
| busy | output | 1 | Self-timed operation in progress |
| arr_we | output | 1 | Array byte write strobe |
| arr_erase | output | 1 | Array erase strobe |
| arr_erase_chip | output | 1 | With `arr_erase`: erase the whole array |
| arr_addr | output | 16 | Write address, or erase base address |
| arr_wdata | output | 8 | Write data |
| wen_clr | output | 1 | Pulse: clear the write-enable latch |

## Verification
The bench targets the wrap points of the page. In one test a burst starts at column 126 and crosses to column 0. In another, 130 bytes overrun the page. A design that does not wrap the pointer would write into the next page, and a design that counts supplied bytes without saturating would issue too many writes or replay stale data. The bench also sends erase addresses on both sides of bit 15. A design that passes the raw address or drops bit 15 shows up as a wrong base address. The remaining tests cover the cases where nothing may happen: an unaligned chip-select rise, write enable low, a locked target, a program with no data, and new commands sent during busy. A design that misses any of these gates starts an operation, and that is visible on `busy` and on the array port.

// File: rtl/pes_pkg.sv
// Package: shared types of the page program and erase sequencer.
package pes_pkg;
    // Operation class of a pending or running command.
    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_PROG = 2'b01,
        OP_SECT = 2'b10,
        OP_CHIP = 2'b11
    } op_e;

    // Sequencer state.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } seq_st_e;
endpackage

// File: rtl/pes_page_buf.sv
// Page buffer: one data byte per column, one write port and one combinational read port.
// Assumes the writer and the reader never use it in the same cycle for conflicting columns.
module pes_page_buf #(
    parameter int PAGE_BYTES = 128,
    parameter int DATA_W     = 8,
    localparam int COL_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [COL_W-1:0]  wr_col,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [COL_W-1:0]  rd_col,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [PAGE_BYTES];

    // Store a byte at the addressed column.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_col] <= wr_data;
    end

    // Present the byte at the read column.
    assign rd_data = mem[rd_col];
endmodule

// File: rtl/pes_timer.sv
// Down-counting cycle timer: loads a count and counts down to zero while enabled.
// Assumes the load value is the number of cycles minus one.
module pes_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             at_zero
);
    logic [CNT_W-1:0] cnt;

    // Load on request, otherwise decrement while running until zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (load)               cnt <= load_val;
        else if (run && cnt != '0)   cnt <= cnt - 1'b1;
    end

    // Flag the final cycle of the window.
    assign at_zero = (cnt == '0);
endmodule

// File: rtl/pes_erase_tgt.sv
// Erase target decoder: reduces any address to the base of its half, or to zero for a full erase.
// Assumes the top address bit selects the half.
module pes_erase_tgt #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              whole,
    output logic [ADDR_W-1:0] base
);
    // Keep only the half-select bit unless the whole array is targeted.
    always_comb begin
        base = '0;
        if (!whole) base[ADDR_W-1] = addr[ADDR_W-1];
    end
endmodule

// File: rtl/pgm_erase_seq.sv
// Page program and erase sequencer.
// Collects program bytes into a wrapping page buffer, commits on an aligned chip-select
// rise when write is enabled and the target is not locked, then runs a busy window that
// replays the bytes (one per clock) or issues one erase pulse, and requests a write-enable
// clear in its last clock. Assumes BYTE_CYC >= 1 and PAGE_BYTES a power of two.
module pgm_erase_seq
    import pes_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 128,
    parameter int BYTE_CYC   = 4,
    parameter int SECT_CYC   = 40,
    parameter int CHIP_CYC   = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [1:0]        cmd_kind,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              data_stb,
    input  logic [DATA_W-1:0] data_byte,
    input  logic              cs_rise,
    input  logic              byte_aligned,
    input  logic              wen,
    input  logic              lock_hit,
    output logic              busy,
    output logic              arr_we,
    output logic              arr_erase,
    output logic              arr_erase_chip,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              wen_clr
);
    localparam int COL_W    = $clog2(PAGE_BYTES);
    localparam int NB_W     = $clog2(PAGE_BYTES + 1);
    localparam int PROG_MAX = PAGE_BYTES * BYTE_CYC;
    localparam int MAX_A    = (PROG_MAX > SECT_CYC) ? PROG_MAX : SECT_CYC;
    localparam int MAX_CYC  = (MAX_A > CHIP_CYC) ? MAX_A : CHIP_CYC;
    localparam int TMR_W    = $clog2(MAX_CYC + 1);
    localparam int PG_W     = ADDR_W - COL_W;

    seq_st_e            state;
    op_e                pend_op, run_op;
    logic [ADDR_W-1:0]  pend_addr, run_addr;
    logic [COL_W-1:0]   col_ptr, wr_col;
    logic [NB_W-1:0]    n_bytes, wr_left;
    logic               first;
    logic               idle, commit, take_byte, tmr_zero;
    logic [TMR_W-1:0]   tmr_val;
    logic [ADDR_W-1:0]  erase_base;
    logic [DATA_W-1:0]  buf_rd;

    assign idle      = (state == ST_IDLE);
    assign take_byte = idle && data_stb && (pend_op == OP_PROG);
    // Commit gate: aligned rise, enabled, unlocked, and a non-empty program if programming.
    assign commit    = idle && cs_rise && byte_aligned && wen && !lock_hit &&
                       (pend_op != OP_NONE) &&
                       ((pend_op != OP_PROG) || (n_bytes != '0));

    // Select the busy-window length of the pending operation (cycles minus one).
    always_comb begin
        case (pend_op)
            OP_SECT: tmr_val = TMR_W'(SECT_CYC - 1);
            OP_CHIP: tmr_val = TMR_W'(CHIP_CYC - 1);
            default: tmr_val = TMR_W'(n_bytes) * TMR_W'(BYTE_CYC) - 1'b1;
        endcase
    end

    // Capture commands and bytes while idle; drop the pending command on every chip-select rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_op   <= OP_NONE;
            pend_addr <= '0;
            col_ptr   <= '0;
            n_bytes   <= '0;
        end else if (idle) begin
            if (cs_rise) begin
                pend_op <= OP_NONE;
                n_bytes <= '0;
            end else if (cmd_start) begin
                pend_op   <= op_e'(cmd_kind);
                pend_addr <= cmd_addr;
                col_ptr   <= cmd_addr[COL_W-1:0];
                n_bytes   <= '0;
            end else if (take_byte) begin
                col_ptr <= (col_ptr == COL_W'(PAGE_BYTES - 1)) ? '0 : col_ptr + 1'b1;
                if (n_bytes != NB_W'(PAGE_BYTES)) n_bytes <= n_bytes + 1'b1;
            end
        end
    end

    // Run the busy window: replay bytes in column order, end when the timer reaches zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            run_op   <= OP_NONE;
            run_addr <= '0;
            wr_col   <= '0;
            wr_left  <= '0;
            first    <= 1'b0;
        end else if (idle) begin
            first <= 1'b0;
            if (commit) begin
                state    <= ST_BUSY;
                run_op   <= pend_op;
                run_addr <= pend_addr;
                wr_col   <= pend_addr[COL_W-1:0];
                wr_left  <= (pend_op == OP_PROG) ? n_bytes : '0;
                first    <= 1'b1;
            end
        end else begin
            first <= 1'b0;
            if (wr_left != '0) begin
                wr_left <= wr_left - 1'b1;
                wr_col  <= (wr_col == COL_W'(PAGE_BYTES - 1)) ? '0 : wr_col + 1'b1;
            end
            if (tmr_zero) state <= ST_IDLE;
        end
    end

    pes_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
        .clk     (clk),
        .wr_en   (take_byte && !cs_rise && !cmd_start),
        .wr_col  (col_ptr),
        .wr_data (data_byte),
        .rd_col  (wr_col),
        .rd_data (buf_rd)
    );

    pes_timer #(.CNT_W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (commit),
        .load_val (tmr_val),
        .run      (state == ST_BUSY),
        .at_zero  (tmr_zero)
    );

    pes_erase_tgt #(.ADDR_W(ADDR_W)) u_tgt (
        .addr  (run_addr),
        .whole (run_op == OP_CHIP),
        .base  (erase_base)
    );

    // Drive the array port and status outputs from the running operation.
    always_comb begin
        busy           = (state == ST_BUSY);
        arr_we         = busy && (run_op == OP_PROG) && (wr_left != '0);
        arr_erase      = busy && first && (run_op == OP_SECT || run_op == OP_CHIP);
        arr_erase_chip = arr_erase && (run_op == OP_CHIP);
        arr_wdata      = buf_rd;
        arr_addr       = (run_op == OP_PROG) ? {run_addr[ADDR_W-1 -: PG_W], wr_col} : erase_base;
        wen_clr        = busy && tmr_zero;
    end
endmodule

// File: rtl/pes_chk.sv
// Checker for the page program and erase sequencer, attached by bind.
module pes_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_rise,
    input logic              byte_aligned,
    input logic              wen,
    input logic              lock_hit,
    input logic              busy,
    input logic              arr_we,
    input logic              arr_erase,
    input logic              arr_erase_chip,
    input logic [ADDR_W-1:0] arr_addr,
    input logic              wen_clr
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !busy && !arr_we && !arr_erase);

    // R4
    aligned_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_rise && byte_aligned));

    // R5
    wen_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wen));

    // R6
    lock_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(lock_hit));

    // R2
    write_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy && !arr_erase);

    // R7
    erase_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_erase |-> $rose(busy));

    // R8
    chip_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_erase_chip |-> arr_erase && (arr_addr == '0));

    // R10
    wen_clr_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wen_clr |=> !busy || $rose(busy));

    // R10
    fall_after_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(wen_clr));
endmodule

bind pgm_erase_seq pes_chk #(.ADDR_W(ADDR_W)) u_pes_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cs_rise        (cs_rise),
    .byte_aligned   (byte_aligned),
    .wen            (wen),
    .lock_hit       (lock_hit),
    .busy           (busy),
    .arr_we         (arr_we),
    .arr_erase      (arr_erase),
    .arr_erase_chip (arr_erase_chip),
    .arr_addr       (arr_addr),
    .wen_clr        (wen_clr)
);

// File: tb/tb_pgm_erase_seq.sv
module tb_pgm_erase_seq;
    localparam int BYTE_CYC = 4;
    localparam int SECT_CYC = 40;
    localparam int CHIP_CYC = 80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic [1:0]  cmd_kind = 2'b00;
    logic [15:0] cmd_addr = '0;
    logic        data_stb = 1'b0;
    logic [7:0]  data_byte = '0;
    logic        cs_rise = 1'b0;
    logic        byte_aligned = 1'b0;
    logic        wen = 1'b0;
    logic        lock_hit = 1'b0;
    logic        busy, arr_we, arr_erase, arr_erase_chip, wen_clr;
    logic [15:0] arr_addr;
    logic [7:0]  arr_wdata;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // Cumulative monitor state, sampled on the falling edge.
    int          n_wr = 0, n_er = 0, n_busy = 0, n_clr = 0;
    logic [15:0] cap_addr [1024];
    logic [7:0]  cap_data [1024];
    logic [15:0] er_addr;
    logic        er_chip;
    int          last_busy_idx = 0, clr_idx = 0;

    always #5 clk = ~clk;

    pgm_erase_seq #(.BYTE_CYC(BYTE_CYC), .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_kind(cmd_kind),
        .cmd_addr(cmd_addr), .data_stb(data_stb), .data_byte(data_byte),
        .cs_rise(cs_rise), .byte_aligned(byte_aligned), .wen(wen), .lock_hit(lock_hit),
        .busy(busy), .arr_we(arr_we), .arr_erase(arr_erase), .arr_erase_chip(arr_erase_chip),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata), .wen_clr(wen_clr)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (arr_we) begin
                cap_addr[n_wr % 1024] = arr_addr;
                cap_data[n_wr % 1024] = arr_wdata;
                n_wr = n_wr + 1;
            end
            if (arr_erase) begin
                er_addr = arr_addr;
                er_chip = arr_erase_chip;
                n_er = n_er + 1;
            end
            if (busy) begin
                n_busy = n_busy + 1;
                last_busy_idx = n_busy;
            end
            if (wen_clr) begin
                n_clr = n_clr + 1;
                clr_idx = n_busy;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [1:0] kind, input logic [15:0] addr);
        cmd_start = 1'b1; cmd_kind = kind; cmd_addr = addr;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        data_stb = 1'b1; data_byte = b;
        @(negedge clk);
        data_stb = 1'b0;
    endtask

    task automatic raise_cs(input logic aligned);
        cs_rise = 1'b1; byte_aligned = aligned;
        @(negedge clk);
        cs_rise = 1'b0; byte_aligned = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    // R1: quiet outputs after reset
    task automatic t_reset();
        chk(!busy && !arr_we && !arr_erase && !wen_clr, "R1 reset outputs",
            {busy, arr_we, arr_erase, wen_clr}, 0);
    endtask

    // R2, R9, R10: short program in the middle of a page
    task automatic t_prog_basic();
        int w0 = n_wr, b0 = n_busy, c0 = n_clr;
        bit ok = 1;
        wen = 1'b1;
        send_cmd(2'b01, 16'h090A);
        for (int i = 0; i < 3; i++) send_byte(8'hA0 + 8'(i));
        raise_cs(1'b1);
        wait_idle();
        chk(n_wr - w0 == 3, "R2 write count", n_wr - w0, 3);
        for (int i = 0; i < 3; i++)
            if (cap_addr[(w0+i)%1024] != 16'h090A + 16'(i) ||
                cap_data[(w0+i)%1024] != 8'hA0 + 8'(i)) ok = 0;
        chk(ok, "R2 write order/addr/data", cap_addr[w0%1024], 16'h090A);
        chk(n_busy - b0 == 3*BYTE_CYC, "R9 program busy length", n_busy - b0, 3*BYTE_CYC);
        chk(n_clr - c0 == 1 && clr_idx == last_busy_idx, "R10 wen_clr in last busy clock",
            n_clr - c0, 1);
    endtask

    // R3: wrap across the end of the page
    task automatic t_prog_wrap();
        int w0 = n_wr;
        logic [15:0] exp_a [4];
        bit ok = 1;
        exp_a[0] = 16'h10FE; exp_a[1] = 16'h10FF; exp_a[2] = 16'h1080; exp_a[3] = 16'h1081;
        send_cmd(2'b01, 16'h10FE);
        for (int i = 0; i < 4; i++) send_byte(8'h50 + 8'(i));
        raise_cs(1'b1);
        wait_idle();
        for (int i = 0; i < 4; i++)
            if (cap_addr[(w0+i)%1024] != exp_a[i] || cap_data[(w0+i)%1024] != 8'h50 + 8'(i)) ok = 0;
        chk(ok && n_wr - w0 == 4, "R3 column wrap", cap_addr[(w0+2)%1024], 16'h1080);
    endtask

    // R3, R9: overrun of 130 bytes
    task automatic t_prog_overrun();
        int w0 = n_wr, b0 = n_busy;
        bit ok = 1;
        send_cmd(2'b01, 16'h2085);
        for (int i = 0; i < 130; i++) send_byte(8'(i));
        raise_cs(1'b1);
        wait_idle();
        chk(n_wr - w0 == 128, "R3 overrun write count", n_wr - w0, 128);
        for (int i = 0; i < 128; i++) begin
            if (cap_addr[(w0+i)%1024] != 16'h2080 + 16'((5 + i) % 128)) ok = 0;
            if (cap_data[(w0+i)%1024] != ((i < 2) ? 8'(i + 128) : 8'(i))) ok = 0;
        end
        chk(ok, "R3 overrun replacement", cap_data[w0%1024], 128);
        chk(n_busy - b0 == 128*BYTE_CYC, "R9 full page busy length", n_busy - b0, 128*BYTE_CYC);
    endtask

    // R4, R5, R6, R12: gated commits produce nothing
    task automatic t_gates();
        int b0, c0, w0;
        b0 = n_busy; w0 = n_wr;
        send_cmd(2'b01, 16'h0300); send_byte(8'h11); raise_cs(1'b0);
        raise_cs(1'b1);
        wait_idle();
        chk(n_busy == b0 && n_wr == w0, "R4 unaligned rise discards", n_busy - b0, 0);
        b0 = n_busy;
        wen = 1'b0;
        send_cmd(2'b10, 16'h0000); raise_cs(1'b1);
        wait_idle();
        chk(n_busy == b0, "R5 no write enable", n_busy - b0, 0);
        wen = 1'b1;
        b0 = n_busy; c0 = n_clr;
        send_cmd(2'b01, 16'h0400); send_byte(8'h22);
        lock_hit = 1'b1; raise_cs(1'b1); lock_hit = 1'b0;
        wait_idle();
        chk(n_busy == b0 && n_clr == c0, "R6 locked target", n_busy - b0, 0);
        b0 = n_busy;
        send_cmd(2'b01, 16'h0500); raise_cs(1'b1);
        wait_idle();
        chk(n_busy == b0, "R12 empty program", n_busy - b0, 0);
    endtask

    // R7, R9: sector erase in both halves
    task automatic t_sector(input logic [15:0] a, input logic [15:0] base);
        int e0 = n_er, b0 = n_busy;
        send_cmd(2'b10, a); raise_cs(1'b1);
        wait_idle();
        chk(n_er - e0 == 1 && er_addr == base && !er_chip, "R7 sector erase base", er_addr, base);
        chk(n_busy - b0 == SECT_CYC, "R9 sector busy length", n_busy - b0, SECT_CYC);
    endtask

    // R8, R9, R11: chip erase, with traffic during busy ignored
    task automatic t_chip();
        int e0 = n_er, b0 = n_busy, w0 = n_wr;
        send_cmd(2'b11, 16'h4321); raise_cs(1'b1);
        send_cmd(2'b01, 16'h0600); send_byte(8'h33); raise_cs(1'b1);
        send_cmd(2'b10, 16'h8000); raise_cs(1'b1);
        wait_idle();
        chk(n_er - e0 == 1 && er_addr == 16'h0000 && er_chip, "R8 chip erase", er_addr, 0);
        chk(n_busy - b0 == CHIP_CYC, "R9 chip busy length", n_busy - b0, CHIP_CYC);
        chk(n_wr == w0, "R11 traffic during busy ignored", n_wr - w0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prog_basic();
        t_prog_wrap();
        t_prog_overrun();
        t_gates();
        t_sector(16'h9ABC, 16'h8000);
        t_sector(16'h1234, 16'h0000);
        t_chip();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule